// File: doc/BRIEF.md
# Byte-Lane Read Parity Checker

This block guards a 64-bit data bus that carries one even-parity bit for every byte. On the write side it computes the parity bits for outgoing data in the same cycle as the data, with no register in the path. On the read side it examines each returned beat in the cycle the data-ready strobe is sampled. Only the byte lanes enabled for the current transfer are examined. An error is reported on an active-low status output two clocks later. A two-stage pipeline carries the report, so consecutive beats are reported independently.

When a faulty beat arrives while the parity-enable input is high, the block captures the cycle's address and control into a set of machine-check registers. If the exception-enable bit is set at that moment, it also raises a machine-check request. The registers hold the first such error until a clear pulse arrives. Any further capturing error only sets an overflow flag. The bus master and the exception handling that consumes the request sit outside this block.

Top module: `byte_lane_parity_chk`

## Requirements
- R1: `wr_par[i]` is the even-parity bit for `wr_data[8i+7:8i]`, so each byte together with its parity bit holds an even number of ones. It is valid in the same cycle as the data.
- R2: A read lane is in error when `rd_data[8i+7:8i]` together with `rd_par[i]` holds an odd number of ones. Lanes are only examined at a rising edge where `rd_rdy` is 1.
- R3: Lane i is examined only when `lane_en_n[i]` is 0. A corrupted lane whose enable bit is 1 causes no status report and no capture.
- R4: A beat sampled with at least one lane in error drives `par_err_n` to 0 for exactly the cycle after the second rising edge that follows the sampling edge. Back-to-back beats each get their own report.
- R5: `par_err_n` is 1 two edges after any edge where no error was sampled, including edges where `rd_rdy` is 0.
- R6: An error sampled with `par_en` = 1 while no capture is held sets `mc_valid`. At the same edge it loads `mc_addr` and `mc_ctrl` from `cyc_addr` and `cyc_ctrl`. An error with `par_en` = 0 captures nothing.
- R7: While `mc_valid` is 1 and no clear arrives, the captured address and control stay unchanged. A further capturing error sets `mc_ovf`.
- R8: `mc_req` is loaded from `mce_en` when a first error is captured. It stays set until cleared and is never 1 while `mc_valid` is 0.
- R9: `mc_clr` = 1 at an edge clears `mc_valid`, `mc_ovf` and `mc_req`. If a capturing error arrives at the same edge, it is recorded as a fresh first error and `mc_ovf` is 0.
- R10: During reset `par_err_n` is 1, and `mc_valid`, `mc_ovf` and `mc_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 64 | Outgoing write data |
| wr_par | output | 8 | Even parity for each write byte |
| rd_data | input | 64 | Returned read data |
| rd_par | input | 8 | Returned parity, one bit per byte |
| lane_en_n | input | 8 | Active-low byte lane enables of the current transfer |
| rd_rdy | input | 1 | Data-ready strobe, beat valid when 1 |
| cyc_addr | input | 32 | Address of the current cycle |
| cyc_ctrl | input | 4 | Control attributes of the current cycle |
| par_en | input | 1 | Parity-enable, sampled with the strobe |
| mce_en | input | 1 | Machine-check exception enable bit |
| mc_clr | input | 1 | Clear pulse for the machine-check registers |
| par_err_n | output | 1 | Active-low parity status, two clocks after the strobe |
| mc_valid | output | 1 | A first error is held |
| mc_ovf | output | 1 | A further error arrived while one was held |
| mc_req | output | 1 | Machine-check exception request |
| mc_addr | output | 32 | Captured address |
| mc_ctrl | output | 4 | Captured control |

## Verification
The hardest cases to reach are the capture registers' corner cases. One is an overflow, which needs a second enabled error while the first is still held. The other is a clear pulse that lands on the same edge as a new capturing error. Directed beats reach both by holding the registers across several transfers and then coinciding `mc_clr` with a faulty beat. A sweep of several hundred back-to-back beats then walks all 256 lane-enable masks against varying corrupted-lane patterns, with the strobe dropped on every fifth cycle. This shows that two-cycle-delayed reports of neighbouring beats never merge.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  // bit that makes a byte plus itself carry an even count of ones
  function automatic logic even_bit(input logic [7:0] b);
    return ^b;
  endfunction

  // a byte/parity pair is bad when its combined count of ones is odd
  function automatic logic lane_bad(input logic [7:0] b, input logic p);
    return (^b) ^ p;
  endfunction
endpackage

// File: rtl/bpc_par_gen.sv
module bpc_par_gen #(
  parameter int LANES = 8
) (
  input  logic [8*LANES-1:0] data,
  output logic [LANES-1:0]   par
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par[i] = bpc_pkg::even_bit(data[8*i +: 8]);
  end
endmodule

// File: rtl/bpc_lane_check.sv
module bpc_lane_check #(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [8*LANES-1:0] data,
  input  logic [LANES-1:0]   par,
  input  logic [LANES-1:0]   en_n,
  input  logic               strobe,
  output logic [LANES-1:0]   lane_err,
  output logic               hit
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_err[i] = strobe && !en_n[i] && bpc_pkg::lane_bad(data[8*i +: 8], par[i]);

    // R3: a disabled lane never reports
    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_n[i] |-> !lane_err[i]);
  end

  assign hit = |lane_err;

  // R2: nothing is flagged without the strobe
  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> !hit);
endmodule

// File: rtl/bpc_err_pipe.sv
module bpc_err_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic err_n
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= hit;
      s2 <= s1;
    end
  end

  assign err_n = !s2;

  // R4: second stage follows the first by one cycle
  p_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s1 |=> s2);
endmodule

// File: rtl/bpc_mc_capture.sv
module bpc_mc_capture #(
  parameter int ADDR_W = 32,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              pen,
  input  logic              mce,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              valid,
  output logic              ovf,
  output logic              req,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic cap, first_cap, over_cap;

  assign cap       = hit && pen;
  assign first_cap = cap && (!valid || clr);
  assign over_cap  = cap && valid && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      ovf    <= 1'b0;
      req    <= 1'b0;
      addr_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (clr) begin
        valid <= 1'b0;
        ovf   <= 1'b0;
        req   <= 1'b0;
      end
      if (first_cap) begin
        valid  <= 1'b1;
        ovf    <= 1'b0;
        req    <= mce;
        addr_q <= addr;
        ctrl_q <= ctrl;
      end
      if (over_cap) ovf <= 1'b1;
    end
  end

  // R6: a first capture records the cycle's address and control
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    first_cap |=> valid && addr_q == $past(addr) && ctrl_q == $past(ctrl));
  // R7: a held capture is not overwritten
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clr) |=> valid && $stable(addr_q) && $stable(ctrl_q));
  p_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
    over_cap |=> ovf);
  // R8: a request only exists alongside a capture
  p_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> valid);
  // R9: clear without a new error empties the registers
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cap) |=> !valid && !ovf && !req);
endmodule

// File: rtl/byte_lane_parity_chk.sv
module byte_lane_parity_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int CTRL_W = 4,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_par,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]  rd_par,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic              rd_rdy,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [CTRL_W-1:0] cyc_ctrl,
  input  logic              par_en,
  input  logic              mce_en,
  input  logic              mc_clr,
  output logic              par_err_n,
  output logic              mc_valid,
  output logic              mc_ovf,
  output logic              mc_req,
  output logic [ADDR_W-1:0] mc_addr,
  output logic [CTRL_W-1:0] mc_ctrl
);
  logic [LANES-1:0] lane_err;
  logic             beat_hit;

  bpc_par_gen #(.LANES(LANES)) u_gen (
    .data (wr_data),
    .par  (wr_par)
  );

  bpc_lane_check #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .data     (rd_data),
    .par      (rd_par),
    .en_n     (lane_en_n),
    .strobe   (rd_rdy),
    .lane_err (lane_err),
    .hit      (beat_hit)
  );

  bpc_err_pipe u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (beat_hit),
    .err_n (par_err_n)
  );

  bpc_mc_capture #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_mc (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (beat_hit),
    .pen    (par_en),
    .mce    (mce_en),
    .clr    (mc_clr),
    .addr   (cyc_addr),
    .ctrl   (cyc_ctrl),
    .valid  (mc_valid),
    .ovf    (mc_ovf),
    .req    (mc_req),
    .addr_q (mc_addr),
    .ctrl_q (mc_ctrl)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_wchk
    // R1: each outgoing byte plus its parity bit is even
    p_wpar_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({wr_data[8*i +: 8], wr_par[i]}) % 2) == 0);
  end

  // R4: a faulty beat is reported two edges later
  p_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_hit |=> ##1 !par_err_n);
  // R5: a clean edge leaves the status high two edges later
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_hit |=> ##1 par_err_n);
endmodule

// File: tb/test_byte_lane_parity_chk.sv
module test_byte_lane_parity_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_par;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_par = '0;
  logic [7:0]  lane_en_n = '0;
  logic        rd_rdy = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [3:0]  cyc_ctrl = '0;
  logic        par_en = 1'b0;
  logic        mce_en = 1'b0;
  logic        mc_clr = 1'b0;
  logic        par_err_n, mc_valid, mc_ovf, mc_req;
  logic [31:0] mc_addr;
  logic [3:0]  mc_ctrl;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  byte_lane_parity_chk i_byte_lane_parity_chk (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_par(wr_par),
    .rd_data(rd_data), .rd_par(rd_par), .lane_en_n(lane_en_n), .rd_rdy(rd_rdy),
    .cyc_addr(cyc_addr), .cyc_ctrl(cyc_ctrl), .par_en(par_en), .mce_en(mce_en),
    .mc_clr(mc_clr), .par_err_n(par_err_n), .mc_valid(mc_valid), .mc_ovf(mc_ovf),
    .mc_req(mc_req), .mc_addr(mc_addr), .mc_ctrl(mc_ctrl)
  );

  function automatic logic odd_ones(input logic [7:0] b);
    int c = 0;
    for (int k = 0; k < 8; k++) if (b[k]) c++;
    return (c % 2) == 1;
  endfunction

  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = odd_ones(d[8*i +: 8]);
    return p;
  endfunction

  function automatic logic [63:0] mkdata(input int t);
    logic [31:0] a, b;
    a = t * 32'h9E3779B1;
    b = (t + 7) * 32'h85EBCA6B;
    return {a, b};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one beat driven at a falling edge, sampled at the next rising edge
  task automatic beat(input logic [63:0] d, input logic [7:0] flip, input logic [7:0] men,
                      input logic [31:0] a, input logic [3:0] c,
                      input logic pe, input logic me, input logic cl, input logic rdy);
    rd_data   = d;
    rd_par    = good_par(d) ^ flip;
    lane_en_n = men;
    cyc_addr  = a;
    cyc_ctrl  = c;
    par_en    = pe;
    mce_en    = me;
    mc_clr    = cl;
    rd_rdy    = rdy;
    @(posedge clk);
    @(negedge clk);
    rd_rdy = 1'b0;
    mc_clr = 1'b0;
    par_en = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired for all requirements");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic hist0, hist1;
    hist0 = 1'b0;
    hist1 = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 par_err_n", {63'd0, par_err_n}, 64'd1);
    chk("R10 mc flags", {61'd0, mc_valid, mc_ovf, mc_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 write parity over varied data
    for (int t = 0; t < 40; t++) begin
      wr_data = mkdata(t * 3 + 1);
      #1;
      chk("R1 wr_par", {56'd0, wr_par}, {56'd0, good_par(wr_data)});
    end

    // R6 error without parity-enable captures nothing
    beat(mkdata(5), 8'h04, 8'h00, 32'h1111_0000, 4'h3, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R6 no capture without par_en", {63'd0, mc_valid}, 64'd0);
    // R6/R8 first capture, exception disabled
    beat(mkdata(6), 8'h01, 8'h00, 32'hA000_1000, 4'h5, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R6 valid", {63'd0, mc_valid}, 64'd1);
    chk("R6 addr", {32'd0, mc_addr}, {32'd0, 32'hA000_1000});
    chk("R6 ctrl", {60'd0, mc_ctrl}, 64'd5);
    chk("R8 no req", {63'd0, mc_req}, 64'd0);
    // R7 second error sets overflow, first is kept
    beat(mkdata(7), 8'h80, 8'h00, 32'hA000_2000, 4'h9, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R7 ovf", {63'd0, mc_ovf}, 64'd1);
    chk("R7 addr kept", {32'd0, mc_addr}, {32'd0, 32'hA000_1000});
    chk("R8 req unchanged on overflow", {63'd0, mc_req}, 64'd0);
    // R9 clear alone
    beat(mkdata(8), 8'h00, 8'h00, 32'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 cleared", {61'd0, mc_valid, mc_ovf, mc_req}, 64'd0);
    // R8 capture with exception enabled
    beat(mkdata(9), 8'h02, 8'h00, 32'hA000_3000, 4'h2, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8 req", {62'd0, mc_valid, mc_req}, 64'd3);
    // R9 clear coinciding with a new error
    beat(mkdata(10), 8'h20, 8'h00, 32'hA000_4000, 4'hC, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R9 fresh capture", {61'd0, mc_valid, mc_ovf, mc_req}, 64'd4);
    chk("R9 new addr", {32'd0, mc_addr}, {32'd0, 32'hA000_4000});
    chk("R9 new ctrl", {60'd0, mc_ctrl}, 64'hC);
    // R3 masked corrupt lane captures nothing
    beat(mkdata(11), 8'h00, 8'h00, 32'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    beat(mkdata(12), 8'h10, 8'h10, 32'hA000_5000, 4'h1, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R3 masked lane no capture", {63'd0, mc_valid}, 64'd0);
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 back-to-back sweep over all enable masks
    for (int t = 0; t < 600; t++) begin
      logic [7:0] m, e;
      logic       r, ex;
      m  = t[7:0];
      e  = 8'((t * 37 + 11) % 256);
      r  = (t % 5) != 4;
      ex = r && ((e & ~m) != 8'h00);
      if (t >= 2) begin
        if (hist1)
          chk("R4 delayed report", {63'd0, par_err_n}, 64'd0);
        else
          chk("R5 quiet status", {63'd0, par_err_n}, 64'd1);
      end
      rd_data   = mkdata(t + 100);
      rd_par    = good_par(rd_data) ^ e;
      lane_en_n = m;
      rd_rdy    = r;
      hist1 = hist0;
      hist0 = ex;
      @(negedge clk);
    end
    rd_rdy = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule